// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block is the internal scratch memory of a small 8-bit controller core, together with the address logic that the core's operand modes need. One 128-byte array, at addresses 00H to 7FH, is reached through four request ports. The byte port uses a direct 7-bit address. The register port names one of eight working registers, and the core's two bank-select bits choose which of four eight-byte banks at the bottom of the array that register lives in. The bit port sets, clears or reads single bits inside a sixteen-byte window at 20H–2FH. The stack port pushes and pops bytes under an 8-bit stack pointer.

At most one array access is served per clock, and a fixed priority picks the winner. Read results appear on a single registered read-data output one clock after the request. The stack pointer is always visible as an output, and it can be loaded directly. A single-bit write is performed inside the array in the same clock as a read-modify-write of the byte that holds the bit.

Top module: `idm_ctrl`

## Requirements
- R1: After reset the stack pointer is 07H, read data is 00H and every array byte reads 00H.
- R2: A byte-port request reads or writes the byte at its 7-bit address, anywhere in 00H–7FH. Read data appears on `rdata` after the clock edge that takes the request. If a read and a write are both requested, the write wins.
- R3: A register request with index r (0–7) and bank bits b targets byte b*8 + r. Bank bits 00 select bank 0 at 00H–07H. If a read and a write are both requested, the write wins.
- R4: A bit set or clear on bit address n (00H–7FH) changes bit n mod 8 of byte 20H + n/8. The other seven bits stay unchanged, and the change completes in one clock. Set wins over clear, and clear wins over read.
- R5: A bit read returns the addressed bit in `rdata` bit 0, with bits 7..1 zero.
- R6: A push first adds one to the stack pointer and then writes the push data at the new pointer value.
- R7: A pop returns the byte at the current pointer on `rdata` and then subtracts one from the pointer.
- R8: A load strobe with no push or pop in the same cycle sets the stack pointer to the load value.
- R9: The stack pointer wraps modulo 256 in both directions, with no error indication. A push from FFH lands at 00H.
- R10: A stack access whose address lies above 7FH reads 00H and discards its write, while the pointer still moves.
- R11: Simultaneous requests are served in the order stack, byte, register, bit. Requests that lose have no effect. A push beats a pop, and a load strobe is ignored while a push or pop is active.
- R12: `rdata` keeps its value in any cycle in which no read is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_addr | input | 7 | Direct byte address |
| byte_rd | input | 1 | Byte read request |
| byte_wr | input | 1 | Byte write request |
| byte_wdata | input | 8 | Byte write data |
| bank_sel | input | 2 | Working-register bank select |
| reg_idx | input | 3 | Working-register index |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_wdata | input | 8 | Register write data |
| bit_addr | input | 7 | Bit address in the bit window |
| bit_set | input | 1 | Set the addressed bit |
| bit_clr | input | 1 | Clear the addressed bit |
| bit_rd | input | 1 | Read the addressed bit |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | 8 | Data to push |
| sp_load | input | 1 | Load the stack pointer directly |
| sp_load_val | input | 8 | Value for a direct load |
| rdata | output | 8 | Registered read data |
| sp | output | 8 | Current stack pointer |

## Verification
Register accesses are tried in all four banks with different indices, and each is read back through the byte port, and the reverse. This separates a correct bank offset from a swapped or dropped bank bit. Bit operations use addresses at both ends of the window and one in the middle, on a byte preloaded with a mixed pattern, so that a wrong byte, a wrong bit position or a lost neighbour bit each shows up. Stack runs start from the reset pointer, from FFH and from 7FH, which covers increment-before-write, read-before-decrement, wraparound and the out-of-range case. Paired requests in one cycle check each step of the priority chain, and each check looks at the loser's target as well.

// File: rtl/idm_pkg.sv
package idm_pkg;
   // which requester owns the array in the current cycle
   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_STACK = 3'd1,
      SRC_BYTE  = 3'd2,
      SRC_REG   = 3'd3,
      SRC_BIT   = 3'd4
   } idm_src_e;
endpackage

// File: rtl/idm_arb.sv
module idm_arb
   import idm_pkg::*;
#(
   parameter int AW        = 7,
   parameter int DW        = 8,
   parameter int SPW       = 8,
   parameter int BSW       = 2,
   parameter int RIW       = 3,
   parameter int BAW       = 7,
   parameter int REGS      = 8,
   parameter int BIT_BASE  = 32,
   localparam int PW       = $clog2(DW)
) (
   input  logic            push,
   input  logic            pop,
   input  logic            byte_rd,
   input  logic            byte_wr,
   input  logic [AW-1:0]   byte_addr,
   input  logic [DW-1:0]   byte_wdata,
   input  logic            reg_rd,
   input  logic            reg_wr,
   input  logic [BSW-1:0]  bank_sel,
   input  logic [RIW-1:0]  reg_idx,
   input  logic [DW-1:0]   reg_wdata,
   input  logic            bit_set,
   input  logic            bit_clr,
   input  logic            bit_rd,
   input  logic [BAW-1:0]  bit_addr,
   input  logic [DW-1:0]   push_data,
   input  logic [SPW-1:0]  sp,
   output idm_src_e        src,
   output logic [AW-1:0]   acc_addr,
   output logic            acc_ok,
   output logic            do_rd,
   output logic            do_wr,
   output logic            do_bitwr,
   output logic            do_bitrd,
   output logic            bit_val,
   output logic [PW-1:0]   bit_pos,
   output logic [DW-1:0]   acc_wdata
);
   logic [SPW-1:0] stk_addr;
   logic [AW-1:0]  reg_addr;
   logic [AW-1:0]  bit_byte;

   assign stk_addr = push ? sp + SPW'(1) : sp;
   assign reg_addr = AW'(bank_sel) * AW'(REGS) + AW'(reg_idx);
   assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr >> PW);

   always_comb begin
      src       = SRC_NONE;
      acc_addr  = '0;
      acc_ok    = 1'b1;
      do_rd     = 1'b0;
      do_wr     = 1'b0;
      do_bitwr  = 1'b0;
      do_bitrd  = 1'b0;
      bit_val   = 1'b0;
      bit_pos   = bit_addr[PW-1:0];
      acc_wdata = '0;
      if (push || pop) begin
         src       = SRC_STACK;
         acc_addr  = stk_addr[AW-1:0];
         acc_ok    = (stk_addr[SPW-1:AW] == '0);
         do_wr     = push;
         do_rd     = !push;
         acc_wdata = push_data;
      end else if (byte_rd || byte_wr) begin
         src       = SRC_BYTE;
         acc_addr  = byte_addr;
         do_wr     = byte_wr;
         do_rd     = !byte_wr;
         acc_wdata = byte_wdata;
      end else if (reg_rd || reg_wr) begin
         src       = SRC_REG;
         acc_addr  = reg_addr;
         do_wr     = reg_wr;
         do_rd     = !reg_wr;
         acc_wdata = reg_wdata;
      end else if (bit_set || bit_clr || bit_rd) begin
         src       = SRC_BIT;
         acc_addr  = bit_byte;
         do_bitwr  = bit_set || bit_clr;
         bit_val   = bit_set;
         do_bitrd  = !(bit_set || bit_clr);
      end
   end
endmodule

// File: rtl/idm_sp.sv
module idm_sp #(
   parameter int          SPW      = 8,
   parameter logic [7:0]  SP_RESET = 8'h07
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_g,
   input  logic           pop_g,
   input  logic           load,
   input  logic [SPW-1:0] load_val,
   output logic [SPW-1:0] sp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp <= SPW'(SP_RESET);
      else if (push_g) sp <= sp + SPW'(1);
      else if (pop_g)  sp <= sp - SPW'(1);
      else if (load)   sp <= load_val;
   end

   // R6 / R9: a push moves the pointer up by one, modulo the width
   a_r6_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
      push_g |=> sp == $past(sp) + SPW'(1));
   // R7 / R9: a pop moves the pointer down by one
   a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      pop_g |=> sp == $past(sp) - SPW'(1));
   // R8: a direct load takes effect when the stack port is idle
   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !push_g && !pop_g) |=> sp == $past(load_val));
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
   parameter int DEPTH   = 128,
   parameter int DW      = 8,
   parameter bit RST_RAM = 1'b1,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] acc_addr,
   input  logic          acc_ok,
   input  logic          do_rd,
   input  logic          do_wr,
   input  logic          do_bitwr,
   input  logic          do_bitrd,
   input  logic          bit_val,
   input  logic [PW-1:0] bit_pos,
   input  logic [DW-1:0] acc_wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   generate
      if (RST_RAM) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (do_wr && acc_ok) begin
               mem[acc_addr] <= acc_wdata;
            end else if (do_bitwr) begin
               mem[acc_addr][bit_pos] <= bit_val;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (do_wr && acc_ok)  mem[acc_addr] <= acc_wdata;
            else if (do_bitwr)    mem[acc_addr][bit_pos] <= bit_val;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata <= '0;
      else if (do_rd)    rdata <= acc_ok ? mem[acc_addr] : '0;
      else if (do_bitrd) rdata <= {{(DW-1){1'b0}}, mem[acc_addr][bit_pos]};
   end

   // R12: no served read leaves the output unchanged
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_rd || do_bitrd) |=> $stable(rdata));
   // R10: an out-of-range stack read yields zero
   a_r10_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd && !acc_ok) |=> rdata == '0);
   // R2 / R6: an accepted write lands in the array
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && acc_ok) |=> mem[$past(acc_addr)] == $past(acc_wdata));
endmodule

// File: rtl/idm_ctrl.sv
module idm_ctrl
   import idm_pkg::*;
#(
   parameter int          DEPTH     = 128,
   parameter int          DW        = 8,
   parameter int          SPW       = 8,
   parameter int          NBANKS    = 4,
   parameter int          REGS      = 8,
   parameter int          BIT_BASE  = 32,
   parameter int          BIT_BYTES = 16,
   parameter logic [7:0]  SP_RESET  = 8'h07,
   parameter bit          RST_RAM   = 1'b1,
   localparam int AW  = $clog2(DEPTH),
   localparam int BSW = $clog2(NBANKS),
   localparam int RIW = $clog2(REGS),
   localparam int BAW = $clog2(BIT_BYTES * DW),
   localparam int PW  = $clog2(DW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  byte_addr,
   input  logic           byte_rd,
   input  logic           byte_wr,
   input  logic [DW-1:0]  byte_wdata,
   input  logic [BSW-1:0] bank_sel,
   input  logic [RIW-1:0] reg_idx,
   input  logic           reg_rd,
   input  logic           reg_wr,
   input  logic [DW-1:0]  reg_wdata,
   input  logic [BAW-1:0] bit_addr,
   input  logic           bit_set,
   input  logic           bit_clr,
   input  logic           bit_rd,
   input  logic           push,
   input  logic           pop,
   input  logic [DW-1:0]  push_data,
   input  logic           sp_load,
   input  logic [SPW-1:0] sp_load_val,
   output logic [DW-1:0]  rdata,
   output logic [SPW-1:0] sp
);
   generate
      if (NBANKS * REGS > BIT_BASE) begin : g_err_banks
         $error("register banks overlap the bit window");
      end
      if (BIT_BASE + BIT_BYTES > DEPTH) begin : g_err_bits
         $error("bit window exceeds the array");
      end
      if (SPW <= AW) begin : g_err_sp
         $error("stack pointer must be wider than the array address");
      end
      if (DEPTH != (1 << AW)) begin : g_err_depth
         $error("depth must be a power of two");
      end
   endgenerate

   idm_src_e      src;
   logic [AW-1:0] acc_addr;
   logic          acc_ok, do_rd, do_wr, do_bitwr, do_bitrd, bit_val;
   logic [PW-1:0] bit_pos;
   logic [DW-1:0] acc_wdata;
   logic          push_g, pop_g;

   idm_arb #(.AW(AW), .DW(DW), .SPW(SPW), .BSW(BSW), .RIW(RIW), .BAW(BAW),
             .REGS(REGS), .BIT_BASE(BIT_BASE)) u_arb (
      .push(push), .pop(pop),
      .byte_rd(byte_rd), .byte_wr(byte_wr), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .bank_sel(bank_sel), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata),
      .bit_set(bit_set), .bit_clr(bit_clr), .bit_rd(bit_rd), .bit_addr(bit_addr),
      .push_data(push_data), .sp(sp),
      .src(src), .acc_addr(acc_addr), .acc_ok(acc_ok), .do_rd(do_rd), .do_wr(do_wr),
      .do_bitwr(do_bitwr), .do_bitrd(do_bitrd), .bit_val(bit_val), .bit_pos(bit_pos),
      .acc_wdata(acc_wdata)
   );

   assign push_g = (src == SRC_STACK) && push;
   assign pop_g  = (src == SRC_STACK) && !push;

   idm_sp #(.SPW(SPW), .SP_RESET(SP_RESET)) u_sp (
      .clk(clk), .rst_n(rst_n), .push_g(push_g), .pop_g(pop_g),
      .load(sp_load), .load_val(sp_load_val), .sp(sp)
   );

   idm_ram #(.DEPTH(DEPTH), .DW(DW), .RST_RAM(RST_RAM)) u_ram (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_ok(acc_ok),
      .do_rd(do_rd), .do_wr(do_wr), .do_bitwr(do_bitwr), .do_bitrd(do_bitrd),
      .bit_val(bit_val), .bit_pos(bit_pos), .acc_wdata(acc_wdata), .rdata(rdata)
   );

   // R11: at most one kind of array operation per cycle
   a_r11_single_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({do_rd, do_wr, do_bitwr, do_bitrd}));
endmodule

// File: tb/sim_idm_ctrl.sv
module sim_idm_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] byte_addr = '0;
   logic       byte_rd = 0, byte_wr = 0;
   logic [7:0] byte_wdata = '0;
   logic [1:0] bank_sel = '0;
   logic [2:0] reg_idx = '0;
   logic       reg_rd = 0, reg_wr = 0;
   logic [7:0] reg_wdata = '0;
   logic [6:0] bit_addr = '0;
   logic       bit_set = 0, bit_clr = 0, bit_rd = 0;
   logic       push = 0, pop = 0;
   logic [7:0] push_data = '0;
   logic       sp_load = 0;
   logic [7:0] sp_load_val = '0;
   logic [7:0] rdata, sp;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   idm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .byte_rd(byte_rd), .byte_wr(byte_wr),
      .byte_wdata(byte_wdata), .bank_sel(bank_sel), .reg_idx(reg_idx), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .bit_addr(bit_addr), .bit_set(bit_set),
      .bit_clr(bit_clr), .bit_rd(bit_rd), .push(push), .pop(pop), .push_data(push_data),
      .sp_load(sp_load), .sp_load_val(sp_load_val), .rdata(rdata), .sp(sp)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // every access task starts at a falling edge and ends at the next one
   task automatic step();
      @(negedge clk);
      byte_rd = 0; byte_wr = 0; reg_rd = 0; reg_wr = 0;
      bit_set = 0; bit_clr = 0; bit_rd = 0; push = 0; pop = 0; sp_load = 0;
   endtask

   task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
      byte_addr = a; byte_wdata = d; byte_wr = 1; step();
   endtask
   task automatic rd_byte(input logic [6:0] a);
      byte_addr = a; byte_rd = 1; step();
   endtask
   task automatic wr_reg(input logic [1:0] b, input logic [2:0] r, input logic [7:0] d);
      bank_sel = b; reg_idx = r; reg_wdata = d; reg_wr = 1; step();
   endtask
   task automatic rd_reg(input logic [1:0] b, input logic [2:0] r);
      bank_sel = b; reg_idx = r; reg_rd = 1; step();
   endtask
   task automatic do_push(input logic [7:0] d);
      push_data = d; push = 1; step();
   endtask
   task automatic do_pop();
      pop = 1; step();
   endtask
   task automatic load_sp(input logic [7:0] v);
      sp_load_val = v; sp_load = 1; step();
   endtask

   task automatic t_reset();
      check("R1 sp reset", sp, 8'h07);
      check("R1 rdata reset", rdata, 8'h00);
      rd_byte(7'h45); check("R1 array cleared", rdata, 8'h00);
   endtask

   task automatic t_byte();
      wr_byte(7'h00, 8'h3C); wr_byte(7'h1F, 8'hC3); wr_byte(7'h2F, 8'h5A);
      wr_byte(7'h30, 8'hA5); wr_byte(7'h7F, 8'h81);
      rd_byte(7'h00); check("R2 byte 00", rdata, 8'h3C);
      rd_byte(7'h1F); check("R2 byte 1F", rdata, 8'hC3);
      rd_byte(7'h2F); check("R2 byte 2F", rdata, 8'h5A);
      rd_byte(7'h30); check("R2 byte 30", rdata, 8'hA5);
      rd_byte(7'h7F); check("R2 byte 7F", rdata, 8'h81);
      byte_addr = 7'h50; byte_wdata = 8'h99; byte_wr = 1; byte_rd = 1; step();
      check("R2 write wins, rdata kept", rdata, 8'h81);
      rd_byte(7'h50); check("R2 write wins, stored", rdata, 8'h99);
   endtask

   task automatic t_banks();
      for (int b = 0; b < 4; b++) begin
         wr_reg(2'(b), 3'(b + 2), 8'h40 + 8'(b));
         rd_byte(7'(b * 8 + b + 2)); check("R3 reg write to byte", rdata, 8'h40 + 8'(b));
         wr_byte(7'(b * 8 + 7), 8'h70 + 8'(b));
         rd_reg(2'(b), 3'd7); check("R3 byte write to reg", rdata, 8'h70 + 8'(b));
      end
   endtask

   task automatic t_bits();
      wr_byte(7'h25, 8'hA5);
      bit_addr = 7'h2B; bit_set = 1; step();
      rd_byte(7'h25); check("R4 set bit 2B", rdata, 8'hAD);
      bit_addr = 7'h28; bit_clr = 1; step();
      rd_byte(7'h25); check("R4 clear bit 28", rdata, 8'hAC);
      bit_addr = 7'h2A; bit_rd = 1; step(); check("R5 read bit 2A", rdata, 8'h01);
      bit_addr = 7'h2C; bit_rd = 1; step(); check("R5 read bit 2C", rdata, 8'h00);
      bit_addr = 7'h00; bit_set = 1; step();
      rd_byte(7'h20); check("R4 set bit 00", rdata, 8'h01);
      bit_addr = 7'h7F; bit_set = 1; step();
      rd_byte(7'h2F); check("R4 set bit 7F", rdata, 8'hDA);
      bit_addr = 7'h29; bit_set = 1; bit_clr = 1; step();
      rd_byte(7'h25); check("R4 set wins over clear", rdata, 8'hAE);
   endtask

   task automatic t_stack();
      do_push(8'h11); check("R6 push sp", sp, 8'h08);
      rd_byte(7'h08); check("R6 push data", rdata, 8'h11);
      do_push(8'h22); check("R6 second push sp", sp, 8'h09);
      do_pop(); check("R7 pop data", rdata, 8'h22); check("R7 pop sp", sp, 8'h08);
      do_pop(); check("R7 pop data 2", rdata, 8'h11); check("R7 pop sp 2", sp, 8'h07);
      load_sp(8'h5F); check("R8 load", sp, 8'h5F);
   endtask

   task automatic t_wrap();
      load_sp(8'hFF);
      do_push(8'h9E); check("R9 wrap up sp", sp, 8'h00);
      rd_byte(7'h00); check("R9 wrap push data", rdata, 8'h9E);
      do_pop(); check("R9 wrap pop data", rdata, 8'h9E); check("R9 wrap down sp", sp, 8'hFF);
   endtask

   task automatic t_high();
      load_sp(8'h7F);
      do_push(8'h55); check("R10 sp moves", sp, 8'h80);
      rd_byte(7'h7F); check("R10 no alias write", rdata, 8'h81);
      rd_byte(7'h00); check("R10 no wrap write", rdata, 8'h9E);
      do_pop(); check("R10 high read zero", rdata, 8'h00); check("R10 sp back", sp, 8'h7F);
   endtask

   task automatic t_prio();
      load_sp(8'h30);
      push_data = 8'h66; push = 1; byte_addr = 7'h40; byte_wdata = 8'h77; byte_wr = 1; step();
      check("R11 stack over byte sp", sp, 8'h31);
      rd_byte(7'h40); check("R11 byte loser", rdata, 8'h00);
      rd_byte(7'h31); check("R11 stack winner", rdata, 8'h66);
      byte_addr = 7'h41; byte_wdata = 8'h12; byte_wr = 1;
      bank_sel = 2'd0; reg_idx = 3'd4; reg_wdata = 8'h34; reg_wr = 1; step();
      rd_byte(7'h41); check("R11 byte winner", rdata, 8'h12);
      rd_byte(7'h04); check("R11 reg loser", rdata, 8'h00);
      bank_sel = 2'd0; reg_idx = 3'd5; reg_wdata = 8'h56; reg_wr = 1;
      bit_addr = 7'h08; bit_set = 1; step();
      rd_byte(7'h05); check("R11 reg winner", rdata, 8'h56);
      rd_byte(7'h21); check("R11 bit loser", rdata, 8'h00);
      sp_load_val = 8'h10; sp_load = 1; pop = 1; step();
      check("R11 pop over load data", rdata, 8'h66); check("R11 pop over load sp", sp, 8'h30);
      push_data = 8'hB7; push = 1; pop = 1; step();
      check("R11 push over pop", sp, 8'h31);
      rd_byte(7'h31); check("R11 push over pop data", rdata, 8'hB7);
   endtask

   task automatic t_hold();
      rd_byte(7'h41); check("R12 setup", rdata, 8'h12);
      wr_byte(7'h50, 8'hEE); check("R12 hold on byte write", rdata, 8'h12);
      bit_addr = 7'h10; bit_set = 1; step(); check("R12 hold on bit set", rdata, 8'h12);
      do_push(8'h01); check("R12 hold on push", rdata, 8'h12);
      step(); check("R12 hold idle", rdata, 8'h12);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset(); t_byte(); t_banks(); t_bits(); t_stack();
      t_wrap(); t_high(); t_prio(); t_hold();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule